// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Bridge

This block lets a big-endian processor reach little-endian ISA I/O ports through a memory-mapped window. A processor request that lands in the 8 MB window starting at 0x8000_0000 becomes one ISA port transaction. The port number comes from the window offset by one of two mappings: a dense one, where the port is the low 16 offset bits, and a sparse one, where each 4 KB page of the window carries 32 consecutive ports. A `map_sparse` input chooses the mapping, and the block samples it when it accepts a request. Halfword and word data have their bytes reversed in both directions. Byte data passes through unchanged.

A small region of four bytes at 0xBFFF_FFF0 serves interrupt acknowledge. A read at its first byte runs one acknowledge handshake with an external interrupt controller and returns the vector. That vector is lane-reversed like any other multi-byte read. Every other access to this region completes at once. An address outside both regions also completes at once, with an error flag and zero data. The block handles one request at a time, and each accepted request produces exactly one single-cycle response.

Top module: `isa_io_bridge`

## Requirements
- R1: A request whose address lies in 0x8000_0000..0x807F_FFFF produces one ISA transaction (`isa_req` high) on the cycle after acceptance. It never produces an acknowledge cycle.
- R2: With `map_sparse` = 0 at acceptance, `isa_port` equals window offset bits [15:0].
- R3: With `map_sparse` = 1 at acceptance, `isa_port` is {offset[22:12], offset[4:0]}, that is offset[4:0] OR (offset[22:12] shifted up by 5).
- R4: Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. Byte accesses use lane 0 (bits [7:0]) unchanged, and the other bits are zero.
- R5: For a halfword, bits [7:0] and [15:8] swap and bits [31:16] are zero. For a word, all four bytes are reversed. Both rules apply to write data toward ISA and to read data toward the processor.
- R6: `isa_req` and all its fields hold steady until `isa_done`. The response follows on the next cycle. `cpu_req_ready` stays low from acceptance through the response cycle.
- R7: A read at 0xBFFF_FFF0 raises `ack_req` until `ack_done`. The response carries the 8-bit vector, zero-extended and then lane-swapped by the request size, with no error.
- R8: Reads at 0xBFFF_FFF1..0xBFFF_FFF3 respond on the cycle after acceptance with zero data and no error. They raise neither `ack_req` nor `isa_req`.
- R9: A write anywhere in the acknowledge region responds on the cycle after acceptance with no error. It raises neither `ack_req` nor `isa_req`.
- R10: Any other address responds on the cycle after acceptance with `cpu_rsp_err` = 1 and zero data. It raises no external cycle.
- R11: After reset, `cpu_req_ready` is 1 and `cpu_rsp_valid`, `isa_req` and `ack_req` are 0.
- R12: Changing `map_sparse` after a request has been accepted does not change the port of that transaction.
- R13: `cpu_rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sparse | input | 1 | 0 = dense port mapping, 1 = sparse page mapping |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Bridge can accept a request |
| cpu_req_addr | input | 32 | Processor physical address |
| cpu_req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_wdata | input | 32 | Processor write data, big-endian lanes |
| cpu_rsp_valid | output | 1 | Response strobe, one cycle |
| cpu_rsp_rdata | output | 32 | Read data toward processor |
| cpu_rsp_err | output | 1 | Address hit no region |
| isa_req | output | 1 | ISA transaction request, held until done |
| isa_port | output | 16 | ISA port address |
| isa_size | output | 2 | Transfer size, same encoding as the request |
| isa_write | output | 1 | ISA direction |
| isa_wdata | output | 32 | Lane-swapped write data |
| isa_done | input | 1 | ISA transaction complete |
| isa_rdata | input | 32 | ISA read data, little-endian lanes |
| ack_req | output | 1 | Interrupt-acknowledge cycle request |
| ack_done | input | 1 | Acknowledge cycle complete |
| ack_vector | input | 8 | Vector returned by the interrupt controller |

## Verification
A wrongly latched port, size or map mode appears on `isa_port` or `isa_size` on the first cycle after acceptance. This is before the responder answers, so the bench catches it within one clock of the request. A control-state error shows up as `cpu_rsp_valid` firing without a completed handshake, as `isa_req` and `ack_req` overlapping, or as `cpu_req_ready` returning too early. The per-cycle monitor flags any of these on the cycle they happen. A lane-ordering fault stays hidden until the response or the ISA write data carries multi-byte values with distinct bytes, so every multi-byte case uses such patterns.

// File: rtl/isa_bridge_pkg.sv
// Package: shared types for the processor-to-ISA bridge.
// Assumes size codes 2 and 3 both mean a 32-bit word.
package isa_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ISA  = 2'd1,
        ST_ACK  = 2'd2,
        ST_RESP = 2'd3
    } bridge_state_t;

endpackage

// File: rtl/io_addr_xlate.sv
// Module: io_addr_xlate
// Decodes a processor address into window hit, acknowledge-region hit and
// vector-read select. It also forms the ISA port number in dense or sparse mode.
// Assumes WIN_BASE is aligned to 2**WIN_LOG2 and ACK_BASE to 16 bytes.
module io_addr_xlate #(
    parameter int          ADDR_W     = 32,
    parameter int          PORT_W     = 16,
    parameter int          WIN_LOG2   = 23,
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter logic [31:0] ACK_BASE   = 32'hBFFF_FFF0,
    parameter int          SPARSE_LO  = 5,
    parameter int          PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sparse_i,
    output logic              win_hit_o,
    output logic              ack_hit_o,
    output logic              ack_vec_o,
    output logic [PORT_W-1:0] port_o
);
    localparam int SPARSE_HI_W = PORT_W - SPARSE_LO;

    logic [WIN_LOG2-1:0] offset;
    logic [PORT_W-1:0]   dense_port;
    logic [PORT_W-1:0]   sparse_port;

    // Region decode from upper address bits.
    always_comb begin
        win_hit_o = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
        ack_hit_o = (addr_i[ADDR_W-1:2] == ACK_BASE[ADDR_W-1:2]);
        ack_vec_o = ack_hit_o && (addr_i[3:0] == 4'h0);
        offset    = addr_i[WIN_LOG2-1:0];
    end

    // Both candidate port numbers, then select by mode.
    always_comb begin
        dense_port  = offset[PORT_W-1:0];
        sparse_port = {offset[PAGE_SHIFT +: SPARSE_HI_W], offset[SPARSE_LO-1:0]};
        port_o      = sparse_i ? sparse_port : dense_port;
    end

endmodule

// File: rtl/lane_swap.sv
// Module: lane_swap
// Reverses byte lanes by transfer size: a byte passes lane 0, a halfword swaps
// lanes 0/1, a word reverses all lanes. Unused lanes read zero.
// Assumes DATA_W is a multiple of 16.
module lane_swap
    import isa_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] word_rev;

    // Full reversal built lane by lane.
    for (genvar g = 0; g < NB; g++) begin : g_rev
        assign word_rev[g*8 +: 8] = data_i[(NB-1-g)*8 +: 8];
    end

    // Pick the reversal matching the transfer size.
    always_comb begin
        data_o = '0;
        case (size_i)
            SZ_BYTE: data_o[7:0]  = data_i[7:0];
            SZ_HALF: data_o[15:0] = {data_i[7:0], data_i[15:8]};
            default: data_o       = word_rev;
        endcase
    end

endmodule

// File: rtl/isa_io_bridge.sv
// Module: isa_io_bridge (top)
// Accepts one processor request at a time. Window hits become a held ISA
// transaction, a vector read runs an interrupt-acknowledge handshake, and
// everything else completes at once. Each request gets one single-cycle
// response. Assumes isa_done/ack_done arrive only while the request is raised.
module isa_io_bridge
    import isa_bridge_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          PORT_W   = 16,
    parameter int          VEC_W    = 8,
    parameter int          WIN_LOG2 = 23,
    parameter logic [31:0] WIN_BASE = 32'h8000_0000,
    parameter logic [31:0] ACK_BASE = 32'hBFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sparse,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [1:0]        cpu_req_size,
    input  logic              cpu_req_write,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              cpu_rsp_err,
    output logic              isa_req,
    output logic [PORT_W-1:0] isa_port,
    output logic [1:0]        isa_size,
    output logic              isa_write,
    output logic [DATA_W-1:0] isa_wdata,
    input  logic              isa_done,
    input  logic [DATA_W-1:0] isa_rdata,
    output logic              ack_req,
    input  logic              ack_done,
    input  logic [VEC_W-1:0]  ack_vector
);
    bridge_state_t     state;
    logic              win_hit, ack_hit, ack_vec;
    logic [PORT_W-1:0] xl_port;
    logic [DATA_W-1:0] wr_swapped, rd_swapped;
    logic [DATA_W-1:0] raw_q;
    logic [PORT_W-1:0] port_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        size_q;
    logic              write_q, err_q;
    logic              accept;

    io_addr_xlate #(
        .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_LOG2(WIN_LOG2),
        .WIN_BASE(WIN_BASE), .ACK_BASE(ACK_BASE),
        .SPARSE_LO(5), .PAGE_SHIFT(12)
    ) u_xlate (
        .addr_i(cpu_req_addr), .sparse_i(map_sparse),
        .win_hit_o(win_hit), .ack_hit_o(ack_hit), .ack_vec_o(ack_vec),
        .port_o(xl_port)
    );

    lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .size_i(cpu_req_size), .data_i(cpu_req_wdata), .data_o(wr_swapped)
    );

    lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .size_i(size_q), .data_i(raw_q), .data_o(rd_swapped)
    );

    assign accept = cpu_req_valid && (state == ST_IDLE);

    // Request sequencing and capture of request fields and returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            raw_q   <= '0;
            port_q  <= '0;
            wdata_q <= '0;
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    port_q  <= xl_port;
                    wdata_q <= wr_swapped;
                    size_q  <= cpu_req_size;
                    write_q <= cpu_req_write;
                    raw_q   <= '0;
                    err_q   <= 1'b0;
                    if (win_hit) begin
                        state <= ST_ISA;
                    end else if (ack_vec && !cpu_req_write) begin
                        state <= ST_ACK;
                    end else begin
                        state <= ST_RESP;
                        err_q <= !ack_hit;
                    end
                end
                ST_ISA: if (isa_done) begin
                    raw_q <= write_q ? '0 : isa_rdata;
                    state <= ST_RESP;
                end
                ST_ACK: if (ack_done) begin
                    raw_q <= {{(DATA_W-VEC_W){1'b0}}, ack_vector};
                    state <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port-side outputs decoded from state and captured fields.
    always_comb begin
        cpu_req_ready = (state == ST_IDLE);
        cpu_rsp_valid = (state == ST_RESP);
        cpu_rsp_rdata = (state == ST_RESP) ? rd_swapped : '0;
        cpu_rsp_err   = (state == ST_RESP) && err_q;
        isa_req       = (state == ST_ISA);
        isa_port      = port_q;
        isa_size      = size_q;
        isa_write     = write_q;
        isa_wdata     = wdata_q;
        ack_req       = (state == ST_ACK);
    end

endmodule

// File: rtl/isa_io_bridge_checker.sv
// Module: isa_io_bridge_checker
// Port-level temporal properties of the bridge, attached by bind.
// Assumes default parameters (32-bit address/data, 16-bit port, 8 MB window).
module isa_io_bridge_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        map_sparse,
    input logic        cpu_req_valid,
    input logic        cpu_req_ready,
    input logic [31:0] cpu_req_addr,
    input logic        cpu_req_write,
    input logic        cpu_rsp_valid,
    input logic [31:0] cpu_rsp_rdata,
    input logic        cpu_rsp_err,
    input logic        isa_req,
    input logic [15:0] isa_port,
    input logic        isa_done,
    input logic        ack_req,
    input logic        ack_done
);
    logic acc;
    logic in_win;
    logic in_ack;
    assign acc    = cpu_req_valid && cpu_req_ready;
    assign in_win = (cpu_req_addr[31:23] == 9'h100);
    assign in_ack = (cpu_req_addr[31:2] == 30'h2FFF_FFFC);

    assert_win_starts_isa_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_win |=> isa_req && !ack_req);

    assert_dense_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_win && !map_sparse |=> isa_port == $past(cpu_req_addr[15:0]));

    assert_sparse_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_win && map_sparse |=>
        isa_port == {$past(cpu_req_addr[22:12]), $past(cpu_req_addr[4:0])});

    assert_isa_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && !isa_done |=> isa_req && $stable(isa_port));

    assert_isa_then_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && isa_done |=> cpu_rsp_valid);

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (isa_req || ack_req || cpu_rsp_valid) |-> !cpu_req_ready);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(isa_req && ack_req));

    assert_ack_then_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && ack_done |=> cpu_rsp_valid && !cpu_rsp_err);

    assert_ack_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_ack && cpu_req_write |=> cpu_rsp_valid && !cpu_rsp_err && !ack_req);

    assert_miss_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !in_win && !in_ack |=> cpu_rsp_valid && cpu_rsp_err && cpu_rsp_rdata == 32'h0);

    assert_rsp_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

endmodule

bind isa_io_bridge isa_io_bridge_checker u_checker (
    .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_req_write(cpu_req_write),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_err(cpu_rsp_err), .isa_req(isa_req), .isa_port(isa_port),
    .isa_done(isa_done), .ack_req(ack_req), .ack_done(ack_done)
);

// File: tb/isa_io_bridge_tb_top.sv
// Bench: behavioural reference for port mapping and lane order; a per-cycle
// monitor watches for unexpected responses and overlapping external cycles.
module isa_io_bridge_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sparse = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_req_addr = '0;
    logic [1:0]  cpu_req_size = '0;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        cpu_rsp_err;
    logic        isa_req;
    logic [15:0] isa_port;
    logic [1:0]  isa_size;
    logic        isa_write;
    logic [31:0] isa_wdata;
    logic        isa_done = 1'b0;
    logic [31:0] isa_rdata = '0;
    logic        ack_req;
    logic        ack_done = 1'b0;
    logic [7:0]  ack_vector = '0;

    int  checks = 0;
    int  errors = 0;
    bit  expect_rsp = 1'b0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_io_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_addr(cpu_req_addr), .cpu_req_size(cpu_req_size),
        .cpu_req_write(cpu_req_write), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .cpu_rsp_err(cpu_rsp_err), .isa_req(isa_req), .isa_port(isa_port),
        .isa_size(isa_size), .isa_write(isa_write), .isa_wdata(isa_wdata),
        .isa_done(isa_done), .isa_rdata(isa_rdata), .ack_req(ack_req),
        .ack_done(ack_done), .ack_vector(ack_vector)
    );

    // Reference: port number from window offset, by arithmetic.
    function automatic logic [15:0] ref_port(logic [31:0] a, bit sparse);
        longint unsigned off;
        off = longint'(a) - 64'h8000_0000;
        if (sparse) return 16'((off % 32) + ((off / 4096) % 2048) * 32);
        return 16'(off % 65536);
    endfunction

    // Reference: lane order by size.
    function automatic logic [31:0] ref_lane(logic [31:0] d, int sz);
        if (sz == 0) return d & 32'hFF;
        if (sz == 1) return ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle monitor: no stray response, no overlapping external cycles.
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check(!(cpu_rsp_valid && !expect_rsp), "R13 stray rsp", 32'(cpu_rsp_valid), 0);
            check(!(isa_req && ack_req), "R6 overlap", 32'({isa_req, ack_req}), 0);
        end
    end

    task automatic drive(logic [31:0] a, int sz, bit wr, logic [31:0] wd);
        check(cpu_req_ready === 1'b1, "R6 ready before request", 32'(cpu_req_ready), 1);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        cpu_req_size  = 2'(sz);
        cpu_req_write = wr;
        cpu_req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    // Window transaction: checks ISA fields, hold, response data.
    task automatic io_txn(logic [31:0] a, int sz, bit wr, logic [31:0] wd,
                          logic [31:0] rd, bit flip, string tag);
        logic [15:0] ep;
        ep = ref_port(a, map_sparse);
        drive(a, sz, wr, wd);
        if (flip) map_sparse = ~map_sparse;
        check(isa_req === 1'b1 && ack_req === 1'b0, {tag, " R1 isa_req"}, 32'(isa_req), 1);
        check(isa_port === ep, {tag, " R2/R3/R12 port"}, 32'(isa_port), 32'(ep));
        check(isa_size === 2'(sz) && isa_write === wr, {tag, " R1 size/dir"},
              32'({isa_size, isa_write}), 32'({2'(sz), wr}));
        if (wr) check(isa_wdata === ref_lane(wd, sz), {tag, " R4/R5 wdata"}, isa_wdata, ref_lane(wd, sz));
        @(negedge clk);
        check(isa_req === 1'b1 && isa_port === ep && cpu_req_ready === 1'b0,
              {tag, " R6 hold"}, 32'(isa_port), 32'(ep));
        isa_done = 1'b1;
        isa_rdata = rd;
        expect_rsp = 1'b1;
        @(negedge clk);
        isa_done = 1'b0;
        check(cpu_rsp_valid === 1'b1 && cpu_rsp_err === 1'b0, {tag, " R6 rsp"}, 32'(cpu_rsp_valid), 1);
        check(cpu_rsp_rdata === (wr ? 32'h0 : ref_lane(rd, sz)), {tag, " R4/R5 rdata"},
              cpu_rsp_rdata, wr ? 32'h0 : ref_lane(rd, sz));
        @(negedge clk);
        expect_rsp = 1'b0;
        if (flip) map_sparse = ~map_sparse;
    endtask

    // Immediate completion: no external cycle, response next cycle.
    task automatic imm_txn(logic [31:0] a, int sz, bit wr, bit exp_err, string tag);
        expect_rsp = 1'b1;
        drive(a, sz, wr, 32'hDEAD_BEEF);
        check(isa_req === 1'b0 && ack_req === 1'b0, {tag, " no external cycle"},
              32'({isa_req, ack_req}), 0);
        check(cpu_rsp_valid === 1'b1 && cpu_rsp_err === exp_err, {tag, " rsp/err"},
              32'({cpu_rsp_valid, cpu_rsp_err}), 32'({1'b1, exp_err}));
        check(cpu_rsp_rdata === 32'h0, {tag, " zero data"}, cpu_rsp_rdata, 0);
        @(negedge clk);
        expect_rsp = 1'b0;
    endtask

    // Vector read through the acknowledge handshake.
    task automatic ack_txn(int sz, logic [7:0] vec, string tag);
        drive(32'hBFFF_FFF0, sz, 1'b0, 32'h0);
        check(ack_req === 1'b1 && isa_req === 1'b0, {tag, " R7 ack_req"}, 32'(ack_req), 1);
        @(negedge clk);
        check(ack_req === 1'b1 && cpu_rsp_valid === 1'b0, {tag, " R7 ack hold"}, 32'(ack_req), 1);
        ack_done = 1'b1;
        ack_vector = vec;
        expect_rsp = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
        check(cpu_rsp_valid === 1'b1 && cpu_rsp_err === 1'b0 &&
              cpu_rsp_rdata === ref_lane(32'(vec), sz), {tag, " R7 vector"},
              cpu_rsp_rdata, ref_lane(32'(vec), sz));
        @(negedge clk);
        expect_rsp = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_req_ready === 1'b1 && cpu_rsp_valid === 1'b0 && isa_req === 1'b0 && ack_req === 1'b0,
              "R11 reset state", 32'({cpu_req_ready, cpu_rsp_valid, isa_req, ack_req}), 32'h8);

        map_sparse = 1'b0;
        io_txn(32'h8000_0061, 0, 1'b1, 32'hAABB_CC5A, 32'h0, 1'b0, "R2 R4 byte write dense");
        io_txn(32'h8001_03F8, 1, 1'b0, 32'h0, 32'hFFFF_1234, 1'b0, "R2 R5 half read dense");
        io_txn(32'h8000_0CF8, 2, 1'b1, 32'h1122_3344, 32'h0, 1'b0, "R5 word write dense");
        io_txn(32'h807F_FFFF, 0, 1'b0, 32'h0, 32'h7766_55A7, 1'b0, "R1 R4 top of window");
        map_sparse = 1'b1;
        io_txn(32'h8041_2345, 2, 1'b0, 32'h0, 32'hCAFE_F00D, 1'b0, "R3 R5 word read sparse");
        io_txn(32'h807F_F01F, 1, 1'b1, 32'h0000_9876, 32'h0, 1'b0, "R3 R5 half write sparse");
        io_txn(32'h8000_1003, 3, 1'b0, 32'h0, 32'h0102_0304, 1'b1, "R12 R3 mode flip after accept");
        map_sparse = 1'b0;
        io_txn(32'h8000_1003, 0, 1'b0, 32'h0, 32'h0000_00E1, 1'b1, "R12 R2 mode flip after accept");

        ack_txn(0, 8'h2A, "R7 byte");
        ack_txn(1, 8'h5C, "R7 half");
        ack_txn(2, 8'h91, "R7 word");
        imm_txn(32'hBFFF_FFF2, 0, 1'b0, 1'b0, "R8 non-vector ack read");
        imm_txn(32'hBFFF_FFF1, 2, 1'b0, 1'b0, "R8 ack read word offset 1");
        imm_txn(32'hBFFF_FFF0, 2, 1'b1, 1'b0, "R9 ack write");
        imm_txn(32'hBFFF_FFF3, 0, 1'b1, 1'b0, "R9 ack write byte 3");
        imm_txn(32'h8080_0000, 0, 1'b0, 1'b1, "R10 just past window");
        imm_txn(32'h7FFF_FFFC, 2, 1'b1, 1'b1, "R10 below window");
        imm_txn(32'hBFFF_FFEC, 2, 1'b0, 1'b1, "R10 below ack region");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule